// File: doc/BRIEF.md
# I2C Slave with 10-bit Addressing

This block is the target side of a two-wire serial bus. It watches an open-drain clock line and data line, recognises bus start, repeated start and stop conditions, and answers to one programmable address that is either 7 or 10 bits wide. Bytes written by the bus master are collected in a shift register and then moved into a receive holding register that the host reads at its own pace. Bytes the master reads are shifted straight out of a single transmit register that the host loads.

The host side is a set of plain control and status pins. A one-cycle interrupt pulse marks every byte accepted into the holding register and every point where the block starts holding the clock line low. When the master reads, the block holds the clock line low until the host has loaded the next byte and pulses the release input. If the 10-bit address has been fully matched earlier in the same transaction, a read started after a repeated start only has to match the header byte.

Top module: `i2c_slave10`

## Requirements
- R1: After reset the block drives neither line low, the receive holding register is empty, the overflow flag and interrupt are low and the clock is not being held.
- R2: With `ten_bit_i` low, an address byte whose bits 7:1 equal `own_addr_i[6:0]` is acknowledged by pulling SDA low during the ninth clock; any other address byte is not acknowledged and the data bytes that follow it are neither acknowledged nor stored.
- R3: With `ten_bit_i` high, a write needs the header byte 1,1,1,1,0,`own_addr_i[9]`,`own_addr_i[8]`,0 (MSB first) followed by a byte equal to `own_addr_i[7:0]`; both are acknowledged and data bytes are then received, while a mismatching second byte is not acknowledged.
- R4: With `ten_bit_i` high, a header byte with its last bit set (read) is acknowledged only when a full 10-bit write match happened after the most recent STOP; after a STOP the same header alone is not acknowledged.
- R5: When the eighth bit of a data byte arrives and the holding register is empty, the byte appears on `rx_data_o`, `rx_full_o` rises and `irq_o` pulses for exactly one cycle in the same cycle; the byte is acknowledged and `rx_pop_i` empties the register.
- R6: A data byte that completes while `rx_full_o` is high sets `ovf_o`, is not acknowledged and leaves `rx_data_o` unchanged; `ovf_clr_i` clears `ovf_o`.
- R7: After it acknowledges a read address, the block holds SCL low and raises `hold_o` (with an `irq_o` pulse) until `release_i`; the byte last written through `tx_wr_i` is then sent MSB first.
- R8: When the master acknowledges a byte it read, the block holds SCL again after the ninth clock; when the master does not acknowledge, the block releases SDA, does not hold SCL and ignores the bus until the next START.
- R9: A START seen at any point, including in the middle of a byte, restarts address reception at its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the clock line |
| sda_i | input | 1 | Sampled level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| own_addr_i | input | 10 | Address this slave answers to |
| ten_bit_i | input | 1 | 1 selects 10-bit address matching |
| rx_data_o | output | 8 | Receive holding register |
| rx_full_o | output | 1 | Holding register has unread data |
| rx_pop_i | input | 1 | Host has read the holding register |
| ovf_o | output | 1 | Sticky receive overflow flag |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| tx_data_i | input | 8 | Byte for the transmit register |
| tx_wr_i | input | 1 | Writes `tx_data_i` into the transmit register |
| release_i | input | 1 | Lets a held clock line go |
| hold_o | output | 1 | Clock line is being held low |
| irq_o | output | 1 | One-cycle event pulse |

## Verification
The hardest state to reach is the read that follows a repeated start in 10-bit mode, because it depends on a match remembered from an earlier phase of the same transaction and is refused once a STOP has intervened. The bench models the master as open-drain drivers combined with the block's pull-downs, performs the two-byte write match, issues a repeated start and reads with the short header, and then repeats the short header after a STOP to see it refused. Clock holding is exercised by a master that waits for the real line level, so the bench can load the transmit register and release at points the block itself chose.

// File: rtl/i2cs_pkg.sv
// Shared constants and the bus-phase type of the two-wire slave.
// Assumes byte-wide transfers and a 10-bit address space.
package i2cs_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 10;
    localparam logic [4:0] HDR_TAG = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed, bus ignored
        ST_HDR,    // first address byte after a start
        ST_LOW,    // second byte of a 10-bit address
        ST_WRITE,  // master writes data to this slave
        ST_READ    // master reads data from this slave
    } phase_t;
endpackage

// File: rtl/i2cs_line_sync.sv
// Brings the two bus lines into the clock domain and derives clock edges
// and start/stop conditions. Assumes both lines idle high.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized levels.
    always_comb begin
        scl_o      = scl_ff[STAGES-1];
        sda_o      = sda_ff[STAGES-1];
        scl_rise_o = scl_o & ~scl_d;
        scl_fall_o = ~scl_o & scl_d;
        start_o    = scl_o & scl_d & sda_d & ~sda_o;
        stop_o     = scl_o & scl_d & ~sda_d & sda_o;
    end
endmodule

// File: rtl/i2cs_addr_match.sv
// Decides the acknowledge and the next phase for an address byte.
// Assumes byte_i is complete; low_i marks the second byte of a 10-bit
// address, hdr_ok_i says a full 10-bit match happened since the last stop.
module i2cs_addr_match
    import i2cs_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ten_i,
    input  logic              low_i,
    input  logic              hdr_ok_i,
    output logic              ack_o,
    output phase_t            nxt_o
);
    logic hdr_hit;

    // Address comparison for the three kinds of address byte.
    always_comb begin
        hdr_hit = (byte_i[7:3] == HDR_TAG) && (byte_i[2:1] == addr_i[9:8]);
        if (low_i) begin
            ack_o = (byte_i == addr_i[7:0]);
            nxt_o = ack_o ? ST_WRITE : ST_IDLE;
        end else if (!ten_i) begin
            ack_o = (byte_i[7:1] == addr_i[6:0]);
            nxt_o = !ack_o ? ST_IDLE : (byte_i[0] ? ST_READ : ST_WRITE);
        end else if (!byte_i[0]) begin
            ack_o = hdr_hit;
            nxt_o = ack_o ? ST_LOW : ST_IDLE;
        end else begin
            ack_o = hdr_hit && hdr_ok_i;
            nxt_o = ack_o ? ST_READ : ST_IDLE;
        end
    end
endmodule

// File: rtl/i2cs_rx_buf.sv
// Receive holding register with full and sticky overflow flags.
// Assumes a push never needs to displace unread data: it is dropped.
module i2cs_rx_buf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    input  logic         ovf_clr_i,
    output logic         full_o,
    output logic [W-1:0] data_o,
    output logic         ovf_o
);
    logic         full_q;
    logic [W-1:0] data_q;
    logic         ovf_q;

    // Fill on push when empty, flag overflow when full, empty on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (pop_i) full_q <= 1'b0;
            if (push_i) begin
                if (!full_q) begin
                    data_q <= data_i;
                    full_q <= 1'b1;
                end else begin
                    ovf_q <= 1'b1;
                end
            end
            if (ovf_clr_i) ovf_q <= 1'b0;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;
    assign ovf_o  = ovf_q;

    AST_OVF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_q && !pop_i && !ovf_clr_i) |=> (ovf_q && $stable(data_q))); // R6
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_q) |=> (full_q && data_q == $past(data_i))); // R5
endmodule

// File: rtl/i2c_slave10.sv
// Two-wire bus slave with 7/10-bit address, host-released clock holding,
// a receive holding register and a single transmit register.
// Assumes open-drain lines: an _oe output of 1 pulls the line low.
module i2c_slave10
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ten_bit_i,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_full_o,
    input  logic              rx_pop_i,
    output logic              ovf_o,
    input  logic              ovf_clr_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_wr_i,
    input  logic              release_i,
    output logic              hold_o,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    phase_t             state_q, nxt_q, m_nxt;
    logic [CNT_W-1:0]   bitcnt_q;
    logic [BYTE_W-1:0]  sreg_q, tx_q, byte_w;
    logic               ack_ph_q, ack_nxt_q, mack_q, hdr_ok_q, rel_q, irq_q;
    logic               m_ack, byte_done, push, rx_full;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    assign byte_w    = {sreg_q[BYTE_W-2:0], sda_s};
    assign byte_done = scl_rise && !ack_ph_q && bitcnt_q == LAST_BIT &&
                       (state_q == ST_HDR || state_q == ST_LOW || state_q == ST_WRITE);
    assign push      = byte_done && state_q == ST_WRITE;

    i2cs_addr_match u_match (
        .byte_i(byte_w), .addr_i(own_addr_i), .ten_i(ten_bit_i),
        .low_i(state_q == ST_LOW), .hdr_ok_i(hdr_ok_q),
        .ack_o(m_ack), .nxt_o(m_nxt)
    );

    i2cs_rx_buf #(.W(BYTE_W)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(byte_w),
        .pop_i(rx_pop_i), .ovf_clr_i(ovf_clr_i), .full_o(rx_full),
        .data_o(rx_data_o), .ovf_o(ovf_o)
    );

    // Bus phase sequencing: bit counting, acknowledge slots and clock holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            nxt_q     <= ST_IDLE;
            bitcnt_q  <= '0;
            sreg_q    <= '0;
            tx_q      <= '0;
            ack_ph_q  <= 1'b0;
            ack_nxt_q <= 1'b0;
            mack_q    <= 1'b0;
            hdr_ok_q  <= 1'b0;
            rel_q     <= 1'b1;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (release_i) rel_q <= 1'b1;
            if (start_det) begin
                state_q  <= ST_HDR;
                bitcnt_q <= '0;
                ack_ph_q <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                bitcnt_q <= '0;
                ack_ph_q <= 1'b0;
                hdr_ok_q <= 1'b0;
            end else if (state_q != ST_IDLE) begin
                if (scl_rise) begin
                    if (state_q == ST_READ) begin
                        if (ack_ph_q) mack_q <= !sda_s;
                    end else if (!ack_ph_q && bitcnt_q < ALL_BITS) begin
                        sreg_q   <= byte_w;
                        bitcnt_q <= bitcnt_q + 1'b1;
                        if (byte_done) begin
                            if (state_q == ST_WRITE) begin
                                ack_nxt_q <= !rx_full;
                                nxt_q     <= ST_WRITE;
                                irq_q     <= !rx_full;
                            end else begin
                                ack_nxt_q <= m_ack;
                                nxt_q     <= m_nxt;
                                if (state_q == ST_LOW) hdr_ok_q <= m_ack;
                            end
                        end
                    end
                end else if (scl_fall) begin
                    if (state_q == ST_READ) begin
                        if (ack_ph_q) begin
                            ack_ph_q <= 1'b0;
                            bitcnt_q <= '0;
                            if (mack_q) begin
                                rel_q <= 1'b0;
                                irq_q <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                            if (bitcnt_q == LAST_BIT) ack_ph_q <= 1'b1;
                        end
                    end else if (ack_ph_q) begin
                        ack_ph_q <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= nxt_q;
                        if (nxt_q == ST_READ) begin
                            rel_q <= 1'b0;
                            irq_q <= 1'b1;
                        end
                    end else if (bitcnt_q == ALL_BITS) begin
                        ack_ph_q <= 1'b1;
                    end
                end
            end
            if (tx_wr_i) tx_q <= tx_data_i;
        end
    end

    // Line drivers: data bit or acknowledge on SDA, holding on SCL.
    always_comb begin
        if (state_q == ST_READ) sda_oe_o = !ack_ph_q && !tx_q[BYTE_W-1];
        else                    sda_oe_o = ack_ph_q && ack_nxt_q;
        scl_oe_o = !rel_q;
    end

    assign hold_o    = !rel_q;
    assign irq_o     = irq_q;
    assign rx_full_o = rx_full;

    AST_READ_NEEDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ten_bit_i && state_q == ST_READ && $past(state_q) != ST_READ) |-> hdr_ok_q); // R4
    AST_HOLD_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rel_q) |-> (state_q == ST_READ)); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R5
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_HDR && bitcnt_q == '0)); // R9
endmodule

// File: tb/test_i2c_slave10.sv
// Scoreboard bench: the write driver queues expected bytes, a monitor pops
// and compares them when the holding register fills.
module test_i2c_slave10;
    localparam int HT = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, m_scl, m_sda;
    logic       scl_oe, sda_oe, scl, sda;
    logic [9:0] own_addr;
    logic       ten_bit, rx_full, rx_pop, mon_pop, sw_pop, ovf, ovf_clr;
    logic [7:0] rx_data, tx_data;
    logic       tx_wr, release_p, hold, irq;

    assign scl    = m_scl & ~scl_oe;
    assign sda    = m_sda & ~sda_oe;
    assign rx_pop = mon_pop | sw_pop;

    i2c_slave10 i_i2c_slave10 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .own_addr_i(own_addr),
        .ten_bit_i(ten_bit), .rx_data_o(rx_data), .rx_full_o(rx_full),
        .rx_pop_i(rx_pop), .ovf_o(ovf), .ovf_clr_i(ovf_clr),
        .tx_data_i(tx_data), .tx_wr_i(tx_wr), .release_i(release_p),
        .hold_o(hold), .irq_o(irq)
    );

    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    bit   auto_pop = 1'b1;
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        while (scl !== 1'b1) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(HT);
        scl_up(); wt(HT);
        m_sda = 1'b0; wt(HT);
        m_scl = 1'b0; wt(HT);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(HT);
        scl_up(); wt(HT);
        m_sda = 1'b1; wt(HT);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wt(HT);
        scl_up(); wt(HT);
        m_scl = 1'b0; wt(HT);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; wt(HT);
        scl_up(); wt(HT/2);
        ack = ~sda;
        wt(HT/2);
        m_scl = 1'b0; wt(HT);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HT);
            scl_up(); wt(HT/2);
            d[i] = sda;
            wt(HT/2);
            m_scl = 1'b0;
        end
        wt(2);
        m_sda = give_ack ? 1'b0 : 1'b1; wt(HT);
        scl_up(); wt(HT);
        m_scl = 1'b0; wt(2);
        m_sda = 1'b1; wt(HT);
    endtask

    // Driver: queue the byte when it should be stored, then send it.
    task automatic send_data(input logic [7:0] b, input logic exp_ack, input string req);
        logic a;
        if (exp_ack) exp_q.push_back(b);
        write_byte(b, a);
        chk(a == exp_ack, req, a, exp_ack);
    endtask

    task automatic sw_load(input logic [7:0] b);
        tx_data = b; tx_wr = 1'b1; wt(1); tx_wr = 1'b0;
    endtask

    task automatic sw_release();
        release_p = 1'b1; wt(1); release_p = 1'b0;
    endtask

    // Monitor: compare each newly stored byte against the scoreboard.
    initial begin
        logic prev;
        prev = 1'b0;
        mon_pop = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && rx_full && !prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected stored byte", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R5 stored byte", rx_data, e);
                end
                chk(irq == 1'b1, "R5 irq with stored byte", irq, 1);
                if (auto_pop) begin
                    mon_pop = 1'b1;
                    @(negedge clk);
                    mon_pop = 1'b0;
                end
            end
            prev = rx_full;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-run actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        own_addr = 10'h02A; ten_bit = 1'b0;
        sw_pop = 1'b0; ovf_clr = 1'b0; tx_data = 8'h00; tx_wr = 1'b0; release_p = 1'b0;
        wt(5);
        rst_n = 1'b1;
        wt(3);
        // R1 reset state
        chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(rx_full == 0 && ovf == 0, "R1 buffer empty", {rx_full, ovf}, 0);
        chk(hold == 0 && irq == 0, "R1 no hold no irq", {hold, irq}, 0);

        // R2 / R5: 7-bit write of two bytes
        bus_start();
        write_byte(8'h54, a); chk(a == 1, "R2 own 7-bit address", a, 1);
        send_data(8'h3C, 1'b1, "R5 ack data 1");
        send_data(8'hC3, 1'b1, "R5 ack data 2");
        bus_stop();

        // R2: foreign address, following byte ignored
        bus_start();
        write_byte(8'h56, a); chk(a == 0, "R2 foreign address", a, 0);
        write_byte(8'h11, a); chk(a == 0, "R2 data after foreign address", a, 0);
        bus_stop();
        wt(5);
        chk(rx_full == 0, "R2 nothing stored", rx_full, 0);

        // R3: 10-bit write
        ten_bit = 1'b1; own_addr = 10'h2B5;
        bus_start();
        write_byte(8'hF4, a); chk(a == 1, "R3 header", a, 1);
        write_byte(8'hB5, a); chk(a == 1, "R3 low byte", a, 1);
        send_data(8'h5A, 1'b1, "R3 data after 10-bit match");
        bus_stop();

        // R3: low byte mismatch
        bus_start();
        write_byte(8'hF4, a); chk(a == 1, "R3 header again", a, 1);
        write_byte(8'hB4, a); chk(a == 0, "R3 wrong low byte", a, 0);
        write_byte(8'h77, a); chk(a == 0, "R3 data after mismatch", a, 0);
        bus_stop();

        // R4 / R7 / R8: 10-bit read after repeated start
        bus_start();
        write_byte(8'hF4, a); chk(a == 1, "R4 header", a, 1);
        write_byte(8'hB5, a); chk(a == 1, "R4 low byte", a, 1);
        bus_start();
        write_byte(8'hF5, a); chk(a == 1, "R4 read header after restart", a, 1);
        wt(10);
        chk(hold == 1, "R7 hold after read address", hold, 1);
        chk(scl == 0, "R7 clock line held", scl, 0);
        sw_load(8'hA5);
        sw_release();
        read_byte(1'b1, d);
        chk(d == 8'hA5, "R7 first read byte", d, 8'hA5);
        wt(10);
        chk(hold == 1, "R8 hold after master ack", hold, 1);
        sw_load(8'h3C);
        sw_release();
        read_byte(1'b0, d);
        chk(d == 8'h3C, "R7 second read byte", d, 8'h3C);
        wt(10);
        chk(hold == 0, "R8 no hold after master nack", hold, 0);
        chk(sda == 1, "R8 data line released", sda, 1);
        bus_stop();

        // R4: short read header after stop is refused
        bus_start();
        write_byte(8'hF5, a); chk(a == 0, "R4 read header without prior match", a, 0);
        bus_stop();
        wt(5);
        chk(hold == 0, "R4 no hold when refused", hold, 0);

        // R6: overflow
        ten_bit = 1'b0; own_addr = 10'h02A; auto_pop = 1'b0;
        bus_start();
        write_byte(8'h54, a); chk(a == 1, "R6 address", a, 1);
        send_data(8'h81, 1'b1, "R6 first byte accepted");
        write_byte(8'h42, a); chk(a == 0, "R6 second byte refused", a, 0);
        bus_stop();
        chk(ovf == 1, "R6 overflow flag", ovf, 1);
        chk(rx_data == 8'h81, "R6 data kept", rx_data, 8'h81);
        ovf_clr = 1'b1; wt(1); ovf_clr = 1'b0; wt(1);
        chk(ovf == 0, "R6 overflow cleared", ovf, 0);
        sw_pop = 1'b1; wt(1); sw_pop = 1'b0; wt(1);
        chk(rx_full == 0, "R5 pop empties", rx_full, 0);
        auto_pop = 1'b1;

        // R9: start in the middle of a byte restarts addressing
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        write_byte(8'h54, a); chk(a == 1, "R9 address after mid-byte start", a, 1);
        send_data(8'h66, 1'b1, "R9 data after restart");
        bus_stop();

        // R7: 7-bit read
        bus_start();
        write_byte(8'h55, a); chk(a == 1, "R7 7-bit read address", a, 1);
        wt(10);
        chk(hold == 1, "R7 hold 7-bit read", hold, 1);
        sw_load(8'h96);
        sw_release();
        read_byte(1'b0, d);
        chk(d == 8'h96, "R7 7-bit read byte", d, 8'h96);
        bus_stop();

        wt(20);
        chk(exp_q.size() == 0, "R5 all expected bytes stored", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule